// File: doc/BRIEF.md
# PCI Satellite Boot Sequencer

This controller decides when an embedded processor acting as a satellite target on a PCI bus may run, and when the bus may reach it. Two flags govern this. A device-busy flag makes the PCI target engine answer with a retry. A CPU-hold flag keeps the core from fetching. A strap input is sampled during reset and picks one of two boot flows. With the strap low, the core starts at once from its local boot device, and local software clears the busy flag when its own setup is done. With the strap high, the core is held. The block then asks a serial-EEPROM loader to fill the configuration space, and the busy flag drops on its own when the load succeeds. A PCI host later clears the hold flag to let the core start at the fixed reset vector.

A management register gives the host two one-shot controls: a warm-reset pulse and a non-maskable interrupt pulse. The block also maps the arbitration pins for satellite operation. The request output floats during PCI reset and is otherwise driven active low. The second request pin is used as the configuration select input. The remaining request pins are held high. The EEPROM serial protocol, the PCI protocol engine and the core are outside the block and appear only as handshake ports.

Top module: `sat_boot_seq`

## Requirements
- R1: A write to address 1 with data bit 0 set gives `warm_rst` high for exactly the one cycle after the write edge.
- R2: A write to address 1 with data bit 1 set gives `nmi_req` high for exactly the one cycle after the write edge.
- R3: After reset, address 0 reads bit 0 (busy) as 1. While busy is 1, `tgt_req` gives `tgt_retry`=1 and `tgt_accept`=0. With busy at 0, it gives `tgt_accept`=1 and `tgt_retry`=0.
- R4: With the strap low at reset, `ee_start` stays low and `cpu_run` is high. Busy stays 1 until a write to address 0 with data bit 0 clear.
- R5: With the strap high at reset, address 0 reads bit 1 (hold) as 1. `ee_start` is high from reset release until the first clock edge. An `ee_done` without `ee_err` clears busy at that edge.
- R6: `cpu_run` is low while hold is 1. A write to address 0 with data bit 1 clear raises `cpu_run` from the next cycle. `cpu_boot_vec` is 0x1FC0_0000.
- R7: While hold is 1, `pmb_req` is 0 whatever `cpu_bus_req` does. Otherwise `pmb_req` follows `cpu_bus_req`.
- R8: `req0_oe` is 0 while `rst_n` is low. Otherwise `req0_oe` is 1 and `req0_o` is the inverse of `arb_req`.
- R9: `idsel` follows `req1_pin`, and every bit of `req_hi` is 1.
- R10: The management bits clear themselves: a read of address 1 returns 0.
- R11: An `ee_done` with `ee_err` leaves busy at 1 and sets the sticky error bit 2 of address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | PCI reset, active low, sampled synchronously |
| strap_suspend | input | 1 | Boot-flow strap, sampled in reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 1 | 0 = control, 1 = management |
| cfg_wdata | input | DW | Write data |
| cfg_rdata | output | DW | Read data for `cfg_addr` |
| ee_start | output | 1 | Starts the EEPROM configuration load |
| ee_done | input | 1 | Load finished |
| ee_err | input | 1 | Load failed (valid with `ee_done`) |
| tgt_req | input | 1 | Incoming PCI target cycle |
| tgt_retry | output | 1 | Answer the cycle with retry |
| tgt_accept | output | 1 | Cycle may proceed |
| cpu_run | output | 1 | Core fetch enable |
| cpu_boot_vec | output | AW | Reset fetch address |
| cpu_bus_req | input | 1 | Core local-bus request |
| pmb_req | output | 1 | Gated local-bus request |
| warm_rst | output | 1 | Warm-reset pulse |
| nmi_req | output | 1 | NMI pulse |
| arb_req | input | 1 | Internal master wants the PCI bus |
| req0_o | output | 1 | Request pin value, active low |
| req0_oe | output | 1 | Request pin drive enable |
| req1_pin | input | 1 | Second request pin, used as config select |
| idsel | output | 1 | Configuration select to the target engine |
| req_hi | output | N_UNUSED | Unused request pins, held high |

## Verification
On every cycle, the assertions check the following. Each pulse must trace back to a management write one cycle earlier. Busy may only fall after a clearing write or a good load. No accept may occur while busy. The load request lasts one cycle. The local bus stays quiet under hold. The request pin floats in reset. A rise of the run enable needs a control write. Only the bench's scenarios show the two complete boot flows: the strap selecting the flow, the auto-clear after a clean load, the error path leaving the device busy, and the exact read-back values.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  typedef enum logic [1:0] {LD_IDLE, LD_KICK, LD_BUSY, LD_FAIL} ld_state_e;

  localparam logic ADDR_CTL  = 1'b0;
  localparam logic ADDR_MGMT = 1'b1;

  localparam int unsigned CTL_BUSY = 0;
  localparam int unsigned CTL_HOLD = 1;
  localparam int unsigned CTL_ERR  = 2;
  localparam int unsigned MG_WRST  = 0;
  localparam int unsigned MG_NMI   = 1;

  function automatic logic must_retry(input logic req, input logic busy);
    return req & busy;
  endfunction

  function automatic logic [2:0] pack_ctl(input logic busy, input logic hold, input logic err);
    logic [2:0] v;
    v = '0;
    v[CTL_BUSY] = busy;
    v[CTL_HOLD] = hold;
    v[CTL_ERR]  = err;
    return v;
  endfunction
endpackage

// File: rtl/sbs_load_fsm.sv
module sbs_load_fsm
  import sbs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic strap_suspend,
  input  logic ee_done,
  input  logic ee_err,
  output logic ee_start,
  output logic load_ok,
  output logic load_fail
);
  ld_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    case (st_q)
      LD_KICK: st_d = LD_BUSY;
      LD_BUSY: if (ee_done) st_d = ee_err ? LD_FAIL : LD_IDLE;
      LD_FAIL: st_d = LD_FAIL;
      default: st_d = LD_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= strap_suspend ? LD_KICK : LD_IDLE;
    else        st_q <= st_d;
  end

  assign ee_start  = (st_q == LD_KICK) && rst_n;
  assign load_ok   = (st_q == LD_BUSY) && ee_done && !ee_err;
  assign load_fail = (st_q == LD_BUSY) && ee_done && ee_err;
endmodule

// File: rtl/sbs_ctrl_regs.sv
module sbs_ctrl_regs
  import sbs_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strap_suspend,
  input  logic          cfg_wr,
  input  logic          cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  input  logic          load_ok,
  input  logic          load_fail,
  output logic [DW-1:0] cfg_rdata,
  output logic          busy,
  output logic          hold,
  output logic          load_err,
  output logic          warm_rst,
  output logic          nmi_req
);
  localparam int unsigned PAD = DW - 3;

  logic busy_q, hold_q, err_q, wrst_q, nmi_q;
  logic wr_ctl, wr_mgmt;
  logic unused_wdata;

  assign wr_ctl       = cfg_wr && (cfg_addr == ADDR_CTL);
  assign wr_mgmt      = cfg_wr && (cfg_addr == ADDR_MGMT);
  assign unused_wdata = ^cfg_wdata[DW-1:2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b1;
      hold_q <= strap_suspend;
      err_q  <= 1'b0;
      wrst_q <= 1'b0;
      nmi_q  <= 1'b0;
    end else begin
      wrst_q <= wr_mgmt && cfg_wdata[MG_WRST];
      nmi_q  <= wr_mgmt && cfg_wdata[MG_NMI];
      if (wr_ctl) begin
        busy_q <= cfg_wdata[CTL_BUSY];
        hold_q <= cfg_wdata[CTL_HOLD];
      end
      if (load_ok)   busy_q <= 1'b0;
      if (load_fail) err_q  <= 1'b1;
    end
  end

  assign cfg_rdata = (cfg_addr == ADDR_CTL) ? {{PAD{1'b0}}, pack_ctl(busy_q, hold_q, err_q)}
                                            : '0;
  assign busy      = busy_q;
  assign hold      = hold_q;
  assign load_err  = err_q;
  assign warm_rst  = wrst_q;
  assign nmi_req   = nmi_q;
endmodule

// File: rtl/sbs_pin_map.sv
module sbs_pin_map #(
  parameter int unsigned N_UNUSED = 4
) (
  input  logic                rst_n,
  input  logic                arb_req,
  input  logic                req1_pin,
  output logic                req0_o,
  output logic                req0_oe,
  output logic                idsel,
  output logic [N_UNUSED-1:0] req_hi
);
  assign req0_oe = rst_n;
  assign req0_o  = ~arb_req;
  assign idsel   = req1_pin;

  for (genvar i = 0; i < N_UNUSED; i++) begin : g_hi
    assign req_hi[i] = 1'b1;
  end
endmodule

// File: rtl/sat_boot_seq.sv
module sat_boot_seq
  import sbs_pkg::*;
#(
  parameter int unsigned DW       = 8,
  parameter int unsigned AW       = 32,
  parameter logic [AW-1:0] BOOT_VEC = 32'h1FC0_0000,
  parameter int unsigned N_UNUSED = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                strap_suspend,
  input  logic                cfg_wr,
  input  logic                cfg_addr,
  input  logic [DW-1:0]       cfg_wdata,
  output logic [DW-1:0]       cfg_rdata,
  output logic                ee_start,
  input  logic                ee_done,
  input  logic                ee_err,
  input  logic                tgt_req,
  output logic                tgt_retry,
  output logic                tgt_accept,
  output logic                cpu_run,
  output logic [AW-1:0]       cpu_boot_vec,
  input  logic                cpu_bus_req,
  output logic                pmb_req,
  output logic                warm_rst,
  output logic                nmi_req,
  input  logic                arb_req,
  output logic                req0_o,
  output logic                req0_oe,
  input  logic                req1_pin,
  output logic                idsel,
  output logic [N_UNUSED-1:0] req_hi
);
  // named internal events, observed by the bound checker
  logic busy, hold, load_err, load_ok, load_fail;

  sbs_load_fsm u_load (
    .clk, .rst_n, .strap_suspend, .ee_done, .ee_err,
    .ee_start, .load_ok, .load_fail
  );

  sbs_ctrl_regs #(.DW(DW)) u_regs (
    .clk, .rst_n, .strap_suspend, .cfg_wr, .cfg_addr, .cfg_wdata,
    .load_ok, .load_fail, .cfg_rdata, .busy, .hold, .load_err,
    .warm_rst, .nmi_req
  );

  sbs_pin_map #(.N_UNUSED(N_UNUSED)) u_pins (
    .rst_n, .arb_req, .req1_pin, .req0_o, .req0_oe, .idsel, .req_hi
  );

  assign tgt_retry    = must_retry(tgt_req, busy);
  assign tgt_accept   = tgt_req && !busy;
  assign cpu_run      = !hold;
  assign pmb_req      = cpu_bus_req && !hold;
  assign cpu_boot_vec = BOOT_VEC;
endmodule

// File: rtl/sbs_checker.sv
module sbs_checker
  import sbs_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_wr,
  input logic          cfg_addr,
  input logic [DW-1:0] cfg_wdata,
  input logic          busy,
  input logic          hold,
  input logic          load_err,
  input logic          load_ok,
  input logic          ee_start,
  input logic          tgt_accept,
  input logic          cpu_run,
  input logic          pmb_req,
  input logic          warm_rst,
  input logic          nmi_req,
  input logic          req0_oe
);
  p_wrst_src_r1: assert property (@(posedge clk) disable iff (!rst_n)
    warm_rst |-> $past(cfg_wr && cfg_addr == ADDR_MGMT && cfg_wdata[MG_WRST]));

  p_nmi_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req |-> $past(cfg_wr && cfg_addr == ADDR_MGMT && cfg_wdata[MG_NMI]));

  p_no_accept_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !tgt_accept);

  p_busy_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past((cfg_wr && cfg_addr == ADDR_CTL && !cfg_wdata[CTL_BUSY]) || load_ok));

  p_start_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ee_start |=> !ee_start);

  p_run_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_run) |-> $past(cfg_wr && cfg_addr == ADDR_CTL));

  p_quiet_bus_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> !pmb_req);

  p_float_reset_r8: assert property (@(posedge clk)
    !rst_n |-> !req0_oe);

  p_err_keeps_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(load_err) |-> (busy || $past(cfg_wr && cfg_addr == ADDR_CTL)));
endmodule

bind sat_boot_seq sbs_checker #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
  .cfg_wdata(cfg_wdata), .busy(busy), .hold(hold), .load_err(load_err),
  .load_ok(load_ok), .ee_start(ee_start), .tgt_accept(tgt_accept),
  .cpu_run(cpu_run), .pmb_req(pmb_req), .warm_rst(warm_rst),
  .nmi_req(nmi_req), .req0_oe(req0_oe)
);

// File: tb/tb_sat_boot_seq.sv
`timescale 1ns/1ps
module tb_sat_boot_seq;
  localparam int DW = 8;
  localparam int AW = 32;
  localparam int NU = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strap_suspend = 1'b0;
  logic cfg_wr = 1'b0, cfg_addr = 1'b0;
  logic [DW-1:0] cfg_wdata = '0;
  logic [DW-1:0] cfg_rdata;
  logic ee_start, ee_done = 1'b0, ee_err = 1'b0;
  logic tgt_req = 1'b0, tgt_retry, tgt_accept;
  logic cpu_run, cpu_bus_req = 1'b0, pmb_req;
  logic [AW-1:0] cpu_boot_vec;
  logic warm_rst, nmi_req;
  logic arb_req = 1'b0, req0_o, req0_oe, req1_pin = 1'b0, idsel;
  logic [NU-1:0] req_hi;

  int n_chk = 0;
  int n_bad = 0;

  // scoreboard queues
  int          q_id[$];
  logic [31:0] q_exp[$];
  string       q_tag[$];

  always #4 clk = ~clk;

  sat_boot_seq #(.DW(DW), .AW(AW), .N_UNUSED(NU)) dut (.*);

  function automatic logic [31:0] sample(input int id);
    case (id)
      0: return 32'(cfg_rdata);
      1: return 32'(cpu_run);
      2: return 32'(pmb_req);
      3: return 32'(tgt_retry);
      4: return 32'(tgt_accept);
      5: return 32'(ee_start);
      6: return 32'(warm_rst);
      7: return 32'(nmi_req);
      8: return 32'(req0_o);
      9: return 32'(req0_oe);
      10: return 32'(idsel);
      11: return 32'(req_hi);
      default: return cpu_boot_vec;
    endcase
  endfunction

  task automatic expect_item(input int id, input logic [31:0] v, input string tag);
    q_id.push_back(id);
    q_exp.push_back(v);
    q_tag.push_back(tag);
  endtask

  // monitor: pops expected items and compares against the settled outputs
  task automatic drain();
    #1;
    while (q_id.size() > 0) begin
      int id;
      logic [31:0] e, a;
      string t;
      id = q_id.pop_front();
      e  = q_exp.pop_front();
      t  = q_tag.pop_front();
      a  = sample(id);
      n_chk++;
      if (a !== e) begin
        n_bad++;
        $display("FAIL %s: signal %0d actual %h expected %h", t, id, a, e);
      end
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [DW-1:0] d);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    tick();
    cfg_wr = 1'b0; cfg_wdata = '0;
  endtask

  task automatic do_reset(input logic s);
    @(negedge clk);
    rst_n = 1'b0; strap_suspend = s;
    repeat (3) tick();
    expect_item(9, 0, "R8 pin floats in reset");
    drain();
    rst_n = 1'b1;
    expect_item(5, 32'(s), "R5 R4 load request at release");
    drain();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    // ---- flow without hold ----
    do_reset(1'b0);
    tick();
    cfg_addr = 1'b0; tgt_req = 1'b1;
    expect_item(0, 1, "R3 busy after reset");
    expect_item(1, 1, "R4 core runs");
    expect_item(5, 0, "R4 no load");
    expect_item(3, 1, "R3 retry");
    expect_item(4, 0, "R3 no accept");
    drain();
    repeat (4) tick();
    expect_item(0, 1, "R4 busy stays set");
    drain();
    wr(1'b0, 8'h00);
    expect_item(0, 0, "R4 software clear");
    expect_item(3, 0, "R3 retry off");
    expect_item(4, 1, "R3 accept");
    drain();
    tgt_req = 1'b0; cpu_bus_req = 1'b1;
    expect_item(2, 1, "R7 bus request passes");
    drain();
    arb_req = 1'b1;
    expect_item(8, 0, "R8 request low");
    expect_item(9, 1, "R8 driven");
    drain();
    arb_req = 1'b0;
    expect_item(8, 1, "R8 request idle high");
    drain();
    req1_pin = 1'b1;
    expect_item(10, 1, "R9 select follows pin");
    expect_item(11, 32'hF, "R9 unused pins high");
    drain();
    wr(1'b1, 8'h01);
    expect_item(6, 1, "R1 warm pulse");
    expect_item(7, 0, "R2 no nmi");
    drain();
    tick();
    expect_item(6, 0, "R1 single cycle");
    drain();
    wr(1'b1, 8'h02);
    cfg_addr = 1'b1;
    expect_item(7, 1, "R2 nmi pulse");
    expect_item(6, 0, "R1 no warm");
    expect_item(0, 0, "R10 mgmt reads zero");
    drain();
    tick();
    expect_item(7, 0, "R2 single cycle");
    drain();

    // ---- flow with hold, clean load ----
    cpu_bus_req = 1'b1; tgt_req = 1'b1;
    do_reset(1'b1);
    tick();
    cfg_addr = 1'b0;
    expect_item(5, 0, "R5 load request one cycle");
    expect_item(0, 3, "R5 busy and hold");
    expect_item(1, 0, "R6 core held");
    expect_item(2, 0, "R7 bus quiet");
    expect_item(12, 32'h1FC0_0000, "R6 boot vector");
    drain();
    ee_done = 1'b1;
    tick();
    ee_done = 1'b0;
    expect_item(0, 2, "R5 busy auto clear");
    expect_item(4, 1, "R5 accept after load");
    expect_item(1, 0, "R6 still held");
    drain();
    wr(1'b0, 8'h00);
    expect_item(1, 1, "R6 host release");
    expect_item(2, 1, "R7 bus after release");
    drain();

    // ---- flow with hold, failing load ----
    do_reset(1'b1);
    tick();
    ee_done = 1'b1; ee_err = 1'b1;
    tick();
    ee_done = 1'b0; ee_err = 1'b0;
    cfg_addr = 1'b0;
    expect_item(0, 7, "R11 error latched busy kept");
    expect_item(3, 1, "R11 retry continues");
    drain();
    repeat (3) tick();
    expect_item(0, 7, "R11 error sticky");
    drain();

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule